// File: doc/BRIEF.md
# Fractional-Rate Pulse Generator

This block emits one-clock-wide pulses whose long-run rate is M/N of the master clock. N is a compile-time modulus of any size and need not be a power of two. A typical value is a reference frequency in hertz, so that M is the pulse rate in hertz. M is a run-time input. The block keeps no phase output. Its only product is the pulse.

A signed accumulator is checked for its sign every cycle. While the accumulator is zero or positive, M is subtracted from it. Once it is negative, the precomputed step N-M is added and a pulse is produced. The value N-M comes from a register stage fed by the rate input. Only one add or subtract therefore sits in the accumulator feedback loop. The pulse times jitter by at most one clock period, and over any stretch of k*N cycles that starts from reset the number of pulses is exactly k*M.

Top module: `pulse_rate_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator clears to zero and `pulse` goes low. After release with a nonzero rate M, `pulse` stays low after the first edge and goes high after the second edge.
- R2: At each edge where the accumulator is negative, the block adds N-M and drives `pulse` high for one cycle. Otherwise it subtracts M and drives `pulse` low. With N=12 and M=3, a pulse appears after edges 2, 6, 10 and so on, counting edges from reset release.
- R3: N is a parameter that need not be a power of two. For a constant M with 0 < M < N, the pulses seen over k*N cycles after reset release number exactly k*M.
- R4: A new `rate` value is captured at one edge and used by the accumulator only at the following edge. From an idle accumulator at zero, a rate step to N gives its first pulse after the third edge following the change.
- R5: With M = 0, `pulse` never goes high.
- R6: With M <= N/2, no two pulses are adjacent: every high cycle of `pulse` is followed by a low cycle.
- R7: A rate change does not clear the accumulator. With N=12, changing M from 3 to 4 just before edge 10 gives pulses after edges 10, 13 and 16, and none after edges 11, 12, 14 or 15.
- R8: M may range from 0 to N. At M = N, `pulse` is high after every edge from the second edge on. A `rate` above N is illegal and is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rate | input | RATE_W | Pulse rate M, from 0 up to MODULUS |
| pulse | output | 1 | Single-cycle output pulse |

## Verification
The sign decision is registered into `pulse`, so a pulse shows up one edge after the accumulator turns negative. A new rate passes through the wrap register first, so the accumulator sees it at the second edge after it is driven, and a pulse that depends on it appears at the third. The bench drives inputs and samples `pulse` on falling edges. It numbers every sample by the count of rising edges since reset release, so each expected pulse position follows from this latency chain. Count windows start at release and last an exact multiple of N.

// File: rtl/prg_pkg.sv
`timescale 1ns/1ps
package prg_pkg;

    // Accumulator action chosen by the sign test.
    typedef enum logic {
        STEP_DOWN = 1'b0,
        STEP_WRAP = 1'b1
    } step_e;

    // Bits needed to hold a rate value from 0 up to the modulus.
    function automatic int rate_bits(input int modulus);
        return (modulus < 2) ? 1 : $clog2(modulus + 1);
    endfunction

    // Signed accumulator width: one sign bit above the rate width.
    function automatic int acc_bits(input int rate_w);
        return rate_w + 1;
    endfunction

endpackage

// File: rtl/prg_wrap_stage.sv
`timescale 1ns/1ps
module prg_wrap_stage #(
    parameter int MODULUS = 50_000_000,
    parameter int RATE_W  = prg_pkg::rate_bits(MODULUS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_in,
    output logic [RATE_W-1:0] rate_q,
    output logic [RATE_W-1:0] wrap_q
);
    localparam logic [RATE_W-1:0] MOD_V = RATE_W'(MODULUS);

    // Loads on every edge, reset included, so that the
    // accumulator step and the wrap step always belong to the same rate.
    always_ff @(posedge clk) begin
        rate_q <= rate_in;
        wrap_q <= MOD_V - rate_in;
    end

    // R8: rates above the modulus are illegal
    p_rate_legal_r8: assert property (@(posedge clk) disable iff (rst)
        rate_in <= MOD_V)
        else $error("rate above modulus");

endmodule

// File: rtl/prg_accum.sv
`timescale 1ns/1ps
module prg_accum #(
    parameter int MODULUS = 50_000_000,
    parameter int RATE_W  = prg_pkg::rate_bits(MODULUS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_q,
    input  logic [RATE_W-1:0] wrap_q,
    output logic              pulse
);
    import prg_pkg::*;

    localparam int ACC_W = acc_bits(RATE_W);
    localparam logic signed [ACC_W-1:0] ACC_MIN = ACC_W'(-MODULUS);
    localparam logic signed [ACC_W-1:0] ACC_MAX = ACC_W'(MODULUS - 1);
    localparam logic [RATE_W-1:0]       HALF    = RATE_W'(MODULUS / 2);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] acc_nx;
    step_e                   step;

    always_comb begin
        step = acc[ACC_W-1] ? STEP_WRAP : STEP_DOWN;
        unique case (step)
            STEP_WRAP: acc_nx = acc + $signed({1'b0, wrap_q});
            default:   acc_nx = acc - $signed({1'b0, rate_q});
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            pulse <= 1'b0;
        end else begin
            acc   <= acc_nx;
            pulse <= (step == STEP_WRAP);
        end
    end

    // R2: the accumulator stays inside [-N, N-1]
    p_acc_range_r2: assert property (@(posedge clk) disable iff (rst)
        (acc >= ACC_MIN) && (acc <= ACC_MAX))
        else $error("accumulator out of range");

    // R6: an isolated pulse under a low rate is followed by a low cycle
    p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (pulse && !$past(pulse) && ($past(rate_q) <= HALF) &&
         ($past(rate_q, 2) <= HALF)) |=> !pulse)
        else $error("adjacent pulses at low rate");

    // R5: with a zero rate a quiet output stays quiet
    p_zero_rate_r5: assert property (@(posedge clk) disable iff (rst)
        (!pulse && ($past(rate_q) == '0)) |=> !pulse)
        else $error("pulse with zero rate");

endmodule

// File: rtl/pulse_rate_gen.sv
`timescale 1ns/1ps
module pulse_rate_gen #(
    parameter int MODULUS = 50_000_000,
    parameter int RATE_W  = prg_pkg::rate_bits(MODULUS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate,
    output logic              pulse
);
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] wrap_q;

    prg_wrap_stage #(.MODULUS(MODULUS), .RATE_W(RATE_W)) u_wrap (
        .clk     (clk),
        .rst     (rst),
        .rate_in (rate),
        .rate_q  (rate_q),
        .wrap_q  (wrap_q)
    );

    prg_accum #(.MODULUS(MODULUS), .RATE_W(RATE_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .rate_q (rate_q),
        .wrap_q (wrap_q),
        .pulse  (pulse)
    );

    // R1: a reset edge always leaves the output low
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> !pulse)
        else $error("pulse after reset edge");

endmodule

// File: tb/pulse_rate_gen_tb.sv
`timescale 1ns/1ps
module pulse_rate_gen_tb;
    localparam int N      = 12;
    localparam int RATE_W = prg_pkg::rate_bits(N);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [RATE_W-1:0] rate = '0;
    logic              pulse;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pulse_rate_gen #(.MODULUS(N)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .rate  (rate),
        .pulse (pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Returns at the falling edge right after release; the next rising edge is edge 1.
    task automatic do_reset(input int m);
        @(negedge clk);
        rate = RATE_W'(m);
        rst  = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic count_window(input int cycles, output int cnt, output int adj);
        bit prev = 1'b0;
        cnt = 0;
        adj = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (pulse) cnt++;
            if (pulse && prev) adj++;
            prev = pulse;
        end
    endtask

    task automatic test_reset;
        do_reset(5);
        check(pulse == 1'b0, "R1 low at release", int'(pulse), 0);
        @(negedge clk);
        check(pulse == 1'b0, "R1 low after edge 1", int'(pulse), 0);
        @(negedge clk);
        check(pulse == 1'b1, "R1 high after edge 2", int'(pulse), 1);
    endtask

    task automatic test_pattern;
        int bad = 0;
        do_reset(3);
        for (int i = 1; i <= 24; i++) begin
            @(negedge clk);
            if (pulse != ((i % 4) == 2)) bad++;
        end
        check(bad == 0, "R2 sign-test pattern M=3", bad, 0);
    endtask

    task automatic test_counts;
        int cnt, adj;
        int rates [4] = '{1, 5, 7, 11};
        foreach (rates[j]) begin
            do_reset(rates[j]);
            count_window(3 * N, cnt, adj);
            check(cnt == 3 * rates[j], "R3 count over 3N cycles", cnt, 3 * rates[j]);
            if (rates[j] <= N / 2)
                check(adj == 0, "R6 no adjacent pulses", adj, 0);
        end
    endtask

    task automatic test_zero;
        int cnt, adj;
        do_reset(0);
        count_window(4 * N, cnt, adj);
        check(cnt == 0, "R5 zero rate silent", cnt, 0);
    endtask

    task automatic test_latency;
        do_reset(0);
        repeat (3) @(negedge clk);
        rate = RATE_W'(N);
        @(negedge clk);
        check(pulse == 1'b0, "R4 low after capture edge", int'(pulse), 0);
        @(negedge clk);
        check(pulse == 1'b0, "R4 low after second edge", int'(pulse), 0);
        @(negedge clk);
        check(pulse == 1'b1, "R4 high after third edge", int'(pulse), 1);
    endtask

    task automatic test_full;
        int cnt, adj;
        do_reset(N);
        @(negedge clk);
        check(pulse == 1'b0, "R8 low after edge 1 at M=N", int'(pulse), 0);
        count_window(24, cnt, adj);
        check(cnt == 24, "R8 continuous at M=N", cnt, 24);
    endtask

    task automatic test_change;
        int bad = 0;
        bit exp_p [7] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
        do_reset(3);
        repeat (9) @(negedge clk);
        rate = RATE_W'(4);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (pulse != exp_p[i]) begin
                bad++;
                $display("FAIL R7 edge %0d actual=%0d expected=%0d", i + 10, pulse, exp_p[i]);
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_pattern();
        test_counts();
        test_zero();
        test_latency();
        test_full();
        test_change();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule